// File: doc/BRIEF.md
# Fine Phase Shift Step Controller

This block sits between a requester and the fine phase shifter of a clock manager. The shifter moves its output phase by one unit for each increment or decrement pulse it receives. It takes a long time to acknowledge each pulse, it never reports its current setting, and it stops at both ends of its range instead of wrapping. A requester hands the controller a signed phase target over a valid/ready handshake. The controller then walks the shifter toward that target one step at a time. It never has more than one step in flight.

The controller keeps its own copy of the phase, because the shifter cannot be read back. Targets outside the usable range are pulled to the nearest end, and a sticky status bit records that this happened. A missing acknowledgement is caught by a timeout. An overflow indication from the shifter blocks all further requests until a synchronous reset clears both the shifter and the controller.

Top module: `pshift_step_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle and no reset is required. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the tracked phase equals the clamped target.
- R2: `req_target` is a two's-complement number. A negative target is treated as 0, and a target above 255 is treated as 255. Either case sets `clamp_sticky`, which stays set until reset.
- R3: At most one step is outstanding. After a `step_pulse`, no further pulse is issued until `step_done` has been received, the wait has timed out, or the controller has gone idle because of an overflow.
- R4: `step_pulse` is exactly one clock cycle wide. `step_dir` (1 = up, 0 = down) is valid one cycle before the pulse and is held stable until `step_done` arrives.
- R5: `cur_phase` changes only in the cycle after a `step_done`, by exactly one unit in the direction of the step. It never goes below 0 or above 255, and it never wraps. `at_max` is high when the phase is 255, and `at_min` is high when it is 0.
- R6: Once `shifter_ovf` has been seen, `reset_needed` is set and stays set until reset. While it is set, `req_ready` is low and no step pulses are issued.
- R7: If `step_done` does not arrive within TIMEOUT_CYC cycles (default 256) after a pulse, `timeout_err` is set and stays set, the controller returns to idle, and `cur_phase` is left unchanged.
- R8: After a synchronous reset, `cur_phase` is 0, all status flags are clear, and `req_ready` is high.
- R9: By default, the bench's shifter model acknowledges a step 87 cycles after the pulse. It saturates at 0 and 255, and it raises overflow when asked to step past either end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also resets the shifter |
| req_valid | input | 1 | Target request valid |
| req_target | input | TGT_W (10) | Signed phase target |
| req_ready | output | 1 | Controller idle and able to accept a request |
| step_pulse | output | 1 | One-cycle step command to the shifter |
| step_dir | output | 1 | Step direction, 1 = up, 0 = down |
| step_done | input | 1 | Step acknowledgement from the shifter |
| shifter_ovf | input | 1 | Overflow indication from the shifter |
| cur_phase | output | PHASE_W (8) | Tracked phase value |
| at_max | output | 1 | Tracked phase is at the top of the range |
| at_min | output | 1 | Tracked phase is zero |
| clamp_sticky | output | 1 | A request was clamped since the last reset |
| reset_needed | output | 1 | Overflow seen; a reset is required |
| timeout_err | output | 1 | A step acknowledgement timed out |

## Verification
A tracked phase that drifts from the real shifter setting does not show up on any controller output by itself. The bench therefore compares `cur_phase` with the model's phase one cycle after every acknowledgement, which catches a drift on the very step that causes it. A sequencer that loses its place shows up as a second pulse before `step_done`, or as a direction change while a step is in flight. Both are visible at the next pulse edge. A broken clamp or timeout path shows up as a final phase that is wrong, or as `req_ready` never returning.

// File: rtl/pshift_pkg.sv
package pshift_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ARM,
        ST_PULSE,
        ST_WAIT
    } seq_state_e;

    localparam logic DIR_UP   = 1'b1;
    localparam logic DIR_DOWN = 1'b0;

    typedef struct packed {
        logic inc;
        logic dec;
    } phase_move_t;

endpackage

// File: rtl/pshift_clamp.sv
module pshift_clamp #(
    parameter int PHASE_W = 8,
    parameter int TGT_W   = 10
) (
    input  logic signed [TGT_W-1:0] tgt,
    output logic [PHASE_W-1:0]      val,
    output logic                    clipped
);
    localparam logic signed [TGT_W-1:0] TOP_S =
        $signed({{(TGT_W-PHASE_W){1'b0}}, {PHASE_W{1'b1}}});

    always_comb begin
        if (tgt < 0) begin
            val     = '0;
            clipped = 1'b1;
        end else if (tgt > TOP_S) begin
            val     = '1;
            clipped = 1'b1;
        end else begin
            val     = tgt[PHASE_W-1:0];
            clipped = 1'b0;
        end
    end
endmodule

// File: rtl/pshift_phase_track.sv
module pshift_phase_track
    import pshift_pkg::*;
#(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  phase_move_t        mv,
    output logic [PHASE_W-1:0] phase,
    output logic               at_max,
    output logic               at_min
);
    localparam logic [PHASE_W-1:0] PH_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else if (mv.inc && phase != PH_MAX)
            phase <= phase + 1'b1;
        else if (mv.dec && phase != '0)
            phase <= phase - 1'b1;
    end

    assign at_max = (phase == PH_MAX);
    assign at_min = (phase == '0);
endmodule

// File: rtl/pshift_seq.sv
module pshift_seq
    import pshift_pkg::*;
#(
    parameter int PHASE_W     = 8,
    parameter int TIMEOUT_CYC = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [PHASE_W-1:0] clamp_val,
    input  logic               clamp_hit,
    input  logic [PHASE_W-1:0] phase,
    input  logic               step_done,
    input  logic               shifter_ovf,
    output logic               req_ready,
    output logic               step_pulse,
    output logic               step_dir,
    output phase_move_t        mv,
    output logic               clamp_sticky,
    output logic               reset_needed,
    output logic               timeout_err
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    seq_state_e         state;
    logic [PHASE_W-1:0] tgt_q;
    logic [CNT_W-1:0]   wait_cnt;

    assign req_ready  = (state == ST_IDLE) && !reset_needed;
    assign step_pulse = (state == ST_PULSE);
    assign mv.inc     = (state == ST_WAIT) && step_done && (step_dir == DIR_UP);
    assign mv.dec     = (state == ST_WAIT) && step_done && (step_dir == DIR_DOWN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            tgt_q        <= '0;
            step_dir     <= DIR_DOWN;
            wait_cnt     <= '0;
            clamp_sticky <= 1'b0;
            reset_needed <= 1'b0;
            timeout_err  <= 1'b0;
        end else begin
            if (shifter_ovf)
                reset_needed <= 1'b1;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid && req_ready) begin
                        tgt_q <= clamp_val;
                        if (clamp_hit)
                            clamp_sticky <= 1'b1;
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (reset_needed || phase == tgt_q) begin
                        state <= ST_IDLE;
                    end else begin
                        step_dir <= (tgt_q > phase) ? DIR_UP : DIR_DOWN;
                        state    <= ST_ARM;
                    end
                end
                ST_ARM: begin
                    state <= (reset_needed || shifter_ovf) ? ST_IDLE : ST_PULSE;
                end
                ST_PULSE: begin
                    wait_cnt <= '0;
                    state    <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (step_done) begin
                        state <= ST_CHECK;
                    end else if (reset_needed) begin
                        state <= ST_IDLE;
                    end else if (wait_cnt == CNT_LAST) begin
                        timeout_err <= 1'b1;
                        state       <= ST_IDLE;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pshift_step_ctrl.sv
module pshift_step_ctrl
    import pshift_pkg::*;
#(
    parameter int PHASE_W     = 8,
    parameter int TGT_W       = 10,
    parameter int TIMEOUT_CYC = 256
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic signed [TGT_W-1:0] req_target,
    output logic                    req_ready,
    output logic                    step_pulse,
    output logic                    step_dir,
    input  logic                    step_done,
    input  logic                    shifter_ovf,
    output logic [PHASE_W-1:0]      cur_phase,
    output logic                    at_max,
    output logic                    at_min,
    output logic                    clamp_sticky,
    output logic                    reset_needed,
    output logic                    timeout_err
);
    logic [PHASE_W-1:0] clamp_val;
    logic               clamp_hit;
    phase_move_t        mv;

    pshift_clamp #(.PHASE_W(PHASE_W), .TGT_W(TGT_W)) u_clamp (
        .tgt     (req_target),
        .val     (clamp_val),
        .clipped (clamp_hit)
    );

    pshift_seq #(.PHASE_W(PHASE_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .clamp_val    (clamp_val),
        .clamp_hit    (clamp_hit),
        .phase        (cur_phase),
        .step_done    (step_done),
        .shifter_ovf  (shifter_ovf),
        .req_ready    (req_ready),
        .step_pulse   (step_pulse),
        .step_dir     (step_dir),
        .mv           (mv),
        .clamp_sticky (clamp_sticky),
        .reset_needed (reset_needed),
        .timeout_err  (timeout_err)
    );

    pshift_phase_track #(.PHASE_W(PHASE_W)) u_track (
        .clk    (clk),
        .rst    (rst),
        .mv     (mv),
        .phase  (cur_phase),
        .at_max (at_max),
        .at_min (at_min)
    );
endmodule

// File: rtl/pshift_step_ctrl_chk.sv
module pshift_step_ctrl_chk #(
    parameter int PHASE_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic               step_pulse,
    input logic               step_dir,
    input logic               step_done,
    input logic [PHASE_W-1:0] cur_phase,
    input logic               reset_needed,
    input logic               timeout_err
);
    logic in_flight;

    always_ff @(posedge clk) begin
        if (rst)
            in_flight <= 1'b0;
        else if (step_pulse)
            in_flight <= 1'b1;
        else if (step_done || req_ready)
            in_flight <= 1'b0;
    end

    assert_accept_drops_ready_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (rst)
        step_pulse |-> !in_flight);

    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (rst)
        step_pulse |=> !step_pulse);

    assert_dir_held_R4: assert property (@(posedge clk) disable iff (rst)
        (step_pulse || in_flight) |-> $stable(step_dir));

    assert_phase_moves_on_done_R5: assert property (@(posedge clk) disable iff (rst)
        (cur_phase != $past(cur_phase) && !$past(rst)) |-> $past(step_done));

    assert_blocked_after_ovf_R6: assert property (@(posedge clk) disable iff (rst)
        reset_needed |-> (!req_ready && !step_pulse));

    assert_reset_needed_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        reset_needed |=> reset_needed);

    assert_timeout_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        timeout_err |=> timeout_err);
endmodule

bind pshift_step_ctrl pshift_step_ctrl_chk #(.PHASE_W(PHASE_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .step_pulse   (step_pulse),
    .step_dir     (step_dir),
    .step_done    (step_done),
    .cur_phase    (cur_phase),
    .reset_needed (reset_needed),
    .timeout_err  (timeout_err)
);

// File: tb/pshift_model.sv
module pshift_model #(
    parameter int LAT = 87
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pulse,
    input  logic       dir,
    input  logic       mute,
    input  logic       force_ovf,
    output logic       done,
    output logic       ovf,
    output logic [7:0] phase
);
    logic     busy;
    logic     dir_q;
    int       cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            dir_q <= 1'b0;
            cnt   <= 0;
            done  <= 1'b0;
            ovf   <= 1'b0;
            phase <= 8'd0;
        end else begin
            done <= 1'b0;
            if (force_ovf)
                ovf <= 1'b1;
            if (pulse && !mute && !ovf) begin
                busy  <= 1'b1;
                dir_q <= dir;
                cnt   <= LAT - 1;
            end else if (busy) begin
                if (cnt == 1) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    if (dir_q) begin
                        if (phase == 8'd255) ovf <= 1'b1;
                        else phase <= phase + 8'd1;
                    end else begin
                        if (phase == 8'd0) ovf <= 1'b1;
                        else phase <= phase - 8'd1;
                    end
                end else begin
                    cnt <= cnt - 1;
                end
            end
        end
    end
endmodule

// File: tb/pshift_step_ctrl_tb.sv
module pshift_step_ctrl_tb;
    localparam int NVEC = 6;
    localparam int VEC_TGT  [NVEC] = '{5, 2, -3, 7, 300, 250};
    localparam int VEC_EXP  [NVEC] = '{5, 2, 0, 7, 255, 250};
    localparam int VEC_CLIP [NVEC] = '{0, 0, 1, 1, 1, 1};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic signed [9:0] req_target = '0;
    logic              req_ready, step_pulse, step_dir, step_done, shifter_ovf;
    logic [7:0]        cur_phase, model_phase;
    logic              at_max, at_min, clamp_sticky, reset_needed, timeout_err;
    logic              mute = 1'b0;
    logic              force_ovf = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int n_pulses = 0;
    int pulse_at = 0;
    bit outstanding = 0;
    bit lat_checked = 0;
    bit cmp_pending = 0;
    bit prev_pulse  = 0;

    always #10 clk = ~clk;

    pshift_step_ctrl u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_target(req_target),
        .req_ready(req_ready), .step_pulse(step_pulse), .step_dir(step_dir),
        .step_done(step_done), .shifter_ovf(shifter_ovf), .cur_phase(cur_phase),
        .at_max(at_max), .at_min(at_min), .clamp_sticky(clamp_sticky),
        .reset_needed(reset_needed), .timeout_err(timeout_err)
    );

    pshift_model #(.LAT(87)) u_model (
        .clk(clk), .rst(rst), .pulse(step_pulse), .dir(step_dir), .mute(mute),
        .force_ovf(force_ovf), .done(step_done), .ovf(shifter_ovf), .phase(model_phase)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: handshake discipline and phase tracking
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            outstanding = 0;
            cmp_pending = 0;
            prev_pulse  = 0;
        end else begin
            if (cmp_pending) begin
                chk(cur_phase == model_phase, "R5 tracked phase vs model", cur_phase, model_phase);
                cmp_pending = 0;
            end
            if (step_pulse) begin
                n_pulses++;
                chk(!outstanding, "R3 pulse before done", 1, 0);
                chk(!prev_pulse, "R4 pulse width", 2, 1);
                outstanding = 1;
                pulse_at = cyc;
            end
            if (step_done) begin
                cmp_pending = 1;
                outstanding = 0;
                if (!lat_checked) begin
                    chk(cyc - pulse_at == 87, "R9 model done latency", cyc - pulse_at, 87);
                    lat_checked = 1;
                end
            end
            if (req_ready) outstanding = 0;
            prev_pulse = step_pulse;
        end
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic send(input int t);
        @(negedge clk);
        req_valid  = 1'b1;
        req_target = 10'(t);
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    task automatic wait_ready(input int lim);
        for (int k = 0; k < lim && !req_ready; k++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int p0;
        do_reset();
        // R8 reset state
        chk(cur_phase == 0, "R8 phase after reset", cur_phase, 0);
        chk(req_ready == 1, "R8 ready after reset", req_ready, 1);
        chk({clamp_sticky, reset_needed, timeout_err} == 0, "R8 flags after reset",
            {clamp_sticky, reset_needed, timeout_err}, 0);
        chk(at_min == 1, "R5 at_min at zero", at_min, 1);

        // Vector walk: R1 R2 R5
        for (int i = 0; i < NVEC; i++) begin
            send(VEC_TGT[i]);
            chk(req_ready == 0, "R1 ready low after accept", req_ready, 0);
            wait_ready(30000);
            chk(cur_phase == VEC_EXP[i], "R1 phase reached target", cur_phase, VEC_EXP[i]);
            chk(clamp_sticky == VEC_CLIP[i], "R2 clamp sticky", clamp_sticky, VEC_CLIP[i]);
            if (VEC_EXP[i] == 255) chk(at_max == 1, "R5 at_max", at_max, 1);
            if (VEC_EXP[i] == 0)   chk(at_min == 1, "R5 at_min", at_min, 1);
        end

        // R5 no wrap: request above top while at 250 then again at 255
        send(400);
        wait_ready(2000);
        chk(cur_phase == 255, "R5 saturate at top", cur_phase, 255);
        p0 = n_pulses;
        send(256);
        wait_ready(200);
        chk(n_pulses == p0, "R5 no step past top", n_pulses - p0, 0);
        chk(cur_phase == 255 && !shifter_ovf, "R5 no wrap at top", cur_phase, 255);
        send(250);
        wait_ready(2000);
        chk(cur_phase == 250, "R5 step down", cur_phase, 250);

        // R7 timeout: muted shifter ignores the pulse
        mute = 1'b1;
        p0 = n_pulses;
        send(251);
        wait_ready(2000);
        chk(timeout_err == 1, "R7 timeout flagged", timeout_err, 1);
        chk(cur_phase == 250, "R7 phase unchanged", cur_phase, 250);
        chk(n_pulses - p0 == 1, "R7 single pulse before timeout", n_pulses - p0, 1);
        mute = 1'b0;
        send(251);
        wait_ready(2000);
        chk(cur_phase == 251 && model_phase == 251, "R7 recovery after timeout", cur_phase, 251);

        // R6 overflow blocks further requests
        @(negedge clk);
        force_ovf = 1'b1;
        @(negedge clk);
        force_ovf = 1'b0;
        @(negedge clk);
        chk(reset_needed == 1, "R6 reset_needed set", reset_needed, 1);
        chk(req_ready == 0, "R6 ready blocked", req_ready, 0);
        p0 = n_pulses;
        @(negedge clk);
        req_valid = 1'b1;
        req_target = 10'sd10;
        repeat (20) @(negedge clk);
        req_valid = 1'b0;
        chk(n_pulses == p0, "R6 no pulses while blocked", n_pulses - p0, 0);
        chk(cur_phase == 251, "R6 phase untouched", cur_phase, 251);

        // R8 reset recovers everything
        do_reset();
        chk(cur_phase == 0, "R8 phase cleared", cur_phase, 0);
        chk(reset_needed == 0 && timeout_err == 0 && clamp_sticky == 0,
            "R8 flags cleared", {reset_needed, timeout_err, clamp_sticky}, 0);
        chk(req_ready == 1, "R8 ready restored", req_ready, 1);
        send(3);
        wait_ready(2000);
        chk(cur_phase == 3 && model_phase == 3, "R8 stepping after reset", cur_phase, 3);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule